// File: doc/BRIEF.md
# Small Signed Integer to Floating-Point Converter

This block turns a small signed two's complement integer into a compact 8-bit floating-point code. It is purely combinational: a new input word produces a new code and flag in the same time step. There is no clock, no stored state and no handshake. The logic is meant to sit in a datapath where the caller samples the outputs whenever it needs them.

Inside, the block first takes the absolute value of the input. A negative input is two's-complement negated, and the sign is kept aside. The block then scans the magnitude from its top bit down for the first one. The position of that one gives the exponent. The bits below it are shifted up to form the fraction, so the leading one itself is implied and is not stored. A zero input has no leading one. For zero the block drives an all-zero code and raises an underflow flag.

Top module: `int2fp_conv`

## Requirements
- R1: The code has three fields. Bit 7 holds the sign, bits 6:4 hold the exponent in excess-3 form, and bits 3:0 hold the fraction that follows an implied leading one.
- R2: For a positive input whose highest set bit is at position p (0 to 2), the sign is 0 and the exponent field is p+3. The fraction holds the p bits below the leading one, left-justified, with zeros filling the rest. Examples: +1 gives 0x30, +5 gives 0x54 and +7 gives 0x5C.
- R3: A negative input is negated to get its magnitude, and that magnitude is encoded as in R2 with the sign bit set to 1. Examples: -1 gives 0xB0 and -3 gives 0xC8.
- R4: The most negative input, -8 (binary 1000), is treated as magnitude 8. Its code is 0xE0: sign 1, exponent field 6, fraction 0.
- R5: An input of zero gives an all-zero code and sets the underflow output to 1.
- R6: For every nonzero input, the underflow output is 0.
- R7: The outputs depend only on the current input. A change of input shows at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_in | input | 4 | Signed two's complement integer to convert |
| fp_out | output | 8 | Floating-point code: sign, excess-3 exponent, fraction |
| underflow | output | 1 | High when the input magnitude is below one (input zero) |

## Verification
Directed groups cover zero, each positive leading-one position, negative values, and the -8 corner on its own. The positive cases separate the exponent from the fraction justification. The negative cases show that the negation and the sign are handled apart from normalisation. The -8 case exposes any negation that overflows the magnitude width. A final sweep applies all 16 inputs in a scrambled order, without waiting on any clock edge, and compares each result with a reference written arithmetically in the bench. That sweep catches any stale or state-dependent output.

// File: rtl/int2fp_pkg.sv
package int2fp_pkg;
  // Default geometry of the converter
  localparam int DEF_INT_W  = 4;  // signed input width
  localparam int DEF_EXP_W  = 3;  // exponent field width
  localparam int DEF_FRAC_W = 4;  // stored fraction width
  localparam int DEF_BIAS   = 3;  // exponent excess
endpackage

// File: rtl/int2fp_abs.sv
// Splits a two's complement word into a sign and an unsigned magnitude.
module int2fp_abs #(
  parameter int W = 4
) (
  input  logic [W-1:0] value,
  output logic [W-1:0] mag,
  output logic         neg
);
  always_comb begin
    neg = value[W-1];
    mag = neg ? (~value + W'(1)) : value;
  end

  // R3: the magnitude of a negative word cancels the word modulo 2^W
  always_comb begin
    if (neg) begin
      a_r3_mag_cancels: assert (W'(value + mag) == '0)
        else $error("negated magnitude does not cancel input");
    end
  end
endmodule

// File: rtl/int2fp_lzc.sv
// Leading-zero counter: the chain records whether a one has been seen at or above each bit.
module int2fp_lzc #(
  parameter int W     = 4,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec,
  output logic [CNT_W-1:0] zeros,
  output logic             all_zero
);
  logic [W:0] seen;

  assign seen[W] = 1'b0;
  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign seen[i] = seen[i+1] | vec[i];
  end

  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      if (!seen[i]) zeros = zeros + CNT_W'(1);
    end
    all_zero = ~seen[0];
  end

  // R2: the count points at a set bit with nothing set above it
  always_comb begin
    if (!all_zero) begin
      a_r2_count_hits_one: assert (vec[W - 1 - int'(zeros)] == 1'b1)
        else $error("leading-zero count misses the first one");
      a_r2_above_clear: assert ((vec >> (W - int'(zeros))) == '0 || zeros == '0)
        else $error("set bit found above the counted position");
    end
  end
endmodule

// File: rtl/int2fp_pack.sv
// Builds the code from sign, magnitude and leading-zero count.
module int2fp_pack #(
  parameter int INT_W  = 4,
  parameter int EXP_W  = 3,
  parameter int FRAC_W = 4,
  parameter int BIAS   = 3,
  parameter int CNT_W  = $clog2(INT_W + 1),
  localparam int OUT_W = 1 + EXP_W + FRAC_W,
  localparam int SH_W  = INT_W + FRAC_W
) (
  input  logic             neg,
  input  logic [INT_W-1:0] mag,
  input  logic [CNT_W-1:0] zeros,
  input  logic             all_zero,
  output logic [OUT_W-1:0] code
);
  logic [SH_W-1:0]   aligned;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  expo;

  always_comb begin
    // shifting past the leading one leaves the bits after it at the top
    aligned = {mag, {FRAC_W{1'b0}}} << (int'(zeros) + 1);
    frac    = aligned[SH_W-1 -: FRAC_W];
    expo    = EXP_W'(BIAS + INT_W - 1 - int'(zeros));
    code    = all_zero ? '0 : {neg, expo, frac};
  end

  // R2: a nonzero magnitude always lands in the valid exponent span
  always_comb begin
    if (!all_zero) begin
      a_r2_exp_span: assert (int'(code[OUT_W-2 -: EXP_W]) >= BIAS &&
                             int'(code[OUT_W-2 -: EXP_W]) <= BIAS + INT_W - 1)
        else $error("exponent outside the span of the input width");
    end
  end
endmodule

// File: rtl/int2fp_conv.sv
// Top: signed integer in, floating-point code and underflow flag out.
module int2fp_conv
  import int2fp_pkg::*;
#(
  parameter int INT_W  = DEF_INT_W,
  parameter int EXP_W  = DEF_EXP_W,
  parameter int FRAC_W = DEF_FRAC_W,
  parameter int BIAS   = DEF_BIAS,
  localparam int OUT_W = 1 + EXP_W + FRAC_W,
  localparam int CNT_W = $clog2(INT_W + 1)
) (
  input  logic [INT_W-1:0] int_in,
  output logic [OUT_W-1:0] fp_out,
  output logic             underflow
);
  logic [INT_W-1:0] mag;
  logic             neg;
  logic [CNT_W-1:0] zeros;
  logic             all_zero;

  int2fp_abs #(.W(INT_W)) u_abs (
    .value (int_in),
    .mag   (mag),
    .neg   (neg)
  );

  int2fp_lzc #(.W(INT_W), .CNT_W(CNT_W)) u_lzc (
    .vec      (mag),
    .zeros    (zeros),
    .all_zero (all_zero)
  );

  int2fp_pack #(
    .INT_W (INT_W), .EXP_W (EXP_W), .FRAC_W (FRAC_W),
    .BIAS  (BIAS),  .CNT_W (CNT_W)
  ) u_pack (
    .neg      (neg),
    .mag      (mag),
    .zeros    (zeros),
    .all_zero (all_zero),
    .code     (fp_out)
  );

  assign underflow = all_zero;

  always_comb begin
    // R5: an underflow always comes with an all-zero code
    if (underflow) begin
      a_r5_zero_code: assert (fp_out == '0)
        else $error("underflow with nonzero code");
    end
    // R6: a nonzero input never raises the flag
    if (int_in != '0) begin
      a_r6_no_false_flag: assert (!underflow)
        else $error("underflow on nonzero input");
      // R3: the sign field follows the input's top bit
      a_r3_sign_field: assert (fp_out[OUT_W-1] == int_in[INT_W-1])
        else $error("sign field differs from input sign");
    end
  end
endmodule

// File: tb/sim_int2fp_conv.sv
module sim_int2fp_conv;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 2000;

  logic       clk = 1'b0;
  logic [3:0] int_in = 4'd0;
  logic [7:0] fp_out;
  logic       underflow;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int2fp_conv u0 (
    .int_in    (int_in),
    .fp_out    (fp_out),
    .underflow (underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference: sign, excess-3 exponent, fraction left-justified after the implied one
  function automatic logic [8:0] ref_model(input int v);
    int m, p, fr;
    logic s;
    s = (v < 0);
    m = s ? -v : v;
    if (m == 0) return {1'b1, 8'h00};
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    fr = ((m - (1 << p)) << (4 - p)) & 15;
    return {1'b0, s, 3'(p + 3), 4'(fr)};
  endfunction

  task automatic check(input string req, input int v,
                       input logic [7:0] exp_code, input logic exp_uf);
    n_checks++;
    if (fp_out !== exp_code || underflow !== exp_uf) begin
      n_errors++;
      $display("FAIL %s input=%0d actual code=%02h uf=%b expected code=%02h uf=%b",
               req, v, fp_out, underflow, exp_code, exp_uf);
    end
  endtask

  task automatic apply(input int v);
    int_in = 4'(v);
    #1;
  endtask

  task automatic t_zero();
    apply(0);
    check("R5", 0, 8'h00, 1'b1);
  endtask

  task automatic t_positive();
    apply(1); check("R2", 1, 8'h30, 1'b0);
    apply(2); check("R2", 2, 8'h40, 1'b0);
    apply(3); check("R2", 3, 8'h48, 1'b0);
    apply(5); check("R2", 5, 8'h54, 1'b0);
    apply(7); check("R2", 7, 8'h5C, 1'b0);
    apply(6); check("R1", 6, {1'b0, 3'd5, 4'b1000}, 1'b0);
  endtask

  task automatic t_negative();
    apply(-1); check("R3", -1, 8'hB0, 1'b0);
    apply(-3); check("R3", -3, 8'hC8, 1'b0);
    apply(-7); check("R3", -7, 8'hDC, 1'b0);
    apply(-4); check("R6", -4, 8'hE0 - 8'h10, 1'b0);
  endtask

  task automatic t_most_negative();
    apply(-8);
    check("R4", -8, 8'hE0, 1'b0);
  endtask

  task automatic t_sweep();
    // R7: scrambled order, no clock edge between applications
    for (int k = 0; k < 16; k++) begin
      int v;
      logic [8:0] r;
      v = ((k * 7 + 3) % 16);
      if (v > 7) v = v - 16;
      apply(v);
      r = ref_model(v);
      check("R7", v, r[7:0], r[8]);
    end
  endtask

  initial begin
    #2;
    check("R5", 0, 8'h00, 1'b1);  // initial state with input at zero
    t_positive();
    t_zero();
    t_negative();
    t_most_negative();
    t_sweep();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule